// File: doc/BRIEF.md
# Triggered Trace Capture Unit

This block is an on-chip debug probe. It watches a wide internal trace vector, waits for a trigger condition programmed by a host, and then stores consecutive trace samples in a small buffer. The host drains the buffer later through the same port. The block also holds a host-written control word, `q`. Logic around the block can take control bits from this word, such as an active-low reset for the logic being debugged. Because `q` is all zeros after reset, such a reset stays asserted until the host releases it.

The host port stands in for a scan-chain user register, but transfers data in parallel chunks. The host first latches an operation code with `ir_we`. It then issues one or more data transfers with `dr_go`. Each transfer carries a segment kind and a bit count. A word can move in one transfer, or be split into a first part, middle parts and a last part. Bits are always placed and returned least significant first. Trace width and buffer depth come from constants in the package. The reset input is active low and synchronous, and is meant to be tied to a clock-locked indication.

Top module: `tracecap`

## Requirements
- R1: While `rst_n` is low and after it rises: `q` is zero, `upd` is low, `dr_rvalid` is low, the trigger is idle, the buffer is empty, and a status read returns 0.
- R2: `ir_we` latches `ir_code` as the current operation. Operation codes are: 1 loads the trigger mask, 2 loads the compare value, 3 writes `q`, 4 reads a captured sample, 5 reads status. A transfer under any other code changes no state, and its single-segment read data is zero.
- R3: A write to `q` takes effect only on its final segment. `q` changes and `upd` is high in the cycle after that transfer is sampled. `upd` lasts one cycle, and `q` changes at no other time.
- R4: The `dr_seg` field uses these codes: 0 single, 1 first, 2 middle, 3 last. `dr_len` gives the bit count, and 0 or any value above the width means the full width. For writes, each segment places its low `dr_len` bits of `dr_wdata` at the running bit position, least significant first. Data bits above `dr_len` are ignored.
- R5: While armed, the trigger fires on the first clock where (trace AND mask) equals (compare AND mask). The trace value at that clock is stored as the first sample. A zero mask fires on the first clock after the mask is loaded.
- R6: After the trigger fires, one sample is stored on every clock until the buffer holds DEPTH samples. Capture then stops and the done flag is set.
- R7: Loading a mask empties the buffer, clears done and arms the trigger.
- R8: A sample read on a single or first segment pops the oldest sample. Each segment returns the next `dr_len` bits of that sample, least significant first, zero-extended. Every transfer yields `dr_rvalid` high, with its data on `dr_rdata`, in the following cycle.
- R9: A sample read while the buffer is empty returns zero and leaves the buffer count unchanged.
- R10: The status word holds done in bit 0, armed in bit 1 and capturing in bit 2. Bits starting at 8 hold the buffer count. All other bits are zero.
- R11: During capture, a host pop in the same cycle as a stored sample keeps the count unchanged. Capture then continues until the buffer is full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trace | input | W | Trace vector being observed |
| q | output | W | Host-written control word |
| upd | output | 1 | One-cycle strobe marking a new value on `q` |
| ir_we | input | 1 | Latch `ir_code` as the current operation |
| ir_code | input | 3 | Operation code |
| dr_go | input | 1 | Perform one data transfer this cycle |
| dr_seg | input | 2 | Segment kind of the transfer |
| dr_len | input | LW | Bit count of the transfer |
| dr_wdata | input | W | Write data, least significant bits first |
| dr_rvalid | output | 1 | Read data valid, one cycle after a transfer |
| dr_rdata | output | W | Read data of the previous transfer |

## Verification
A host pop and a trigger-driven push can fall in the same clock. The bench waits for the trigger clock and then issues a sample read on the very next clock. At that point the buffer holds exactly one sample while capture is still running. The read must return the triggering sample. The status count must then show a full buffer holding the sixteen samples after it, with none lost and none repeated.

// File: rtl/tracecap_pkg.sv
package tracecap_pkg;

    localparam int TRACE_W   = 64;
    localparam int CAP_DEPTH = 16;
    localparam int LEN_W     = 7;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_MASK = 3'd1,
        OP_CMP  = 3'd2,
        OP_OUT  = 3'd3,
        OP_READ = 3'd4,
        OP_STAT = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        SEG_ONE   = 2'd0,
        SEG_FIRST = 2'd1,
        SEG_MID   = 2'd2,
        SEG_LAST  = 2'd3
    } seg_e;

    typedef enum logic [1:0] {
        CAP_IDLE,
        CAP_ARMED,
        CAP_RUN,
        CAP_DONE
    } cap_e;

    function automatic logic seg_opens(input seg_e s);
        return (s == SEG_ONE) || (s == SEG_FIRST);
    endfunction

    function automatic logic seg_closes(input seg_e s);
        return (s == SEG_ONE) || (s == SEG_LAST);
    endfunction

endpackage

// File: rtl/tracecap_seg.sv
module tracecap_seg
    import tracecap_pkg::*;
#(
    parameter int W  = TRACE_W,
    parameter int LW = LEN_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  seg_e          seg,
    input  logic [LW-1:0] len,
    input  logic [W-1:0]  wdata,
    input  logic [W-1:0]  load_val,
    output logic          commit,
    output logic [W-1:0]  word,
    output logic          rvalid,
    output logic [W-1:0]  rdata
);
    localparam logic [LW-1:0] FULL_N = LW'(W);

    logic [W-1:0]  acc, sh, base_acc, base_sh, m;
    logic [LW-1:0] pos, base_pos, n;
    logic          opens;

    always_comb begin
        n        = (len == '0 || len > FULL_N) ? FULL_N : len;
        m        = (n >= FULL_N) ? '1 : ((W'(1) << n) - W'(1));
        opens    = seg_opens(seg);
        base_acc = opens ? '0 : acc;
        base_pos = opens ? '0 : pos;
        base_sh  = opens ? load_val : sh;
        word     = base_acc | ((wdata & m) << base_pos);
        commit   = go && seg_closes(seg);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc    <= '0;
            pos    <= '0;
            sh     <= '0;
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= go;
            if (go) begin
                acc   <= word;
                pos   <= base_pos + n;
                sh    <= base_sh >> n;
                rdata <= base_sh & m;
            end
        end
    end
endmodule

// File: rtl/tracecap_fifo.sv
module tracecap_fifo #(
    parameter int W     = 64,
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rp, wp;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign head    = mem[rp];

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rp    <= '0;
            wp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= step(wp);
            if (do_pop)  rp <= step(rp);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    p_empty_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !clr) |=> (count == '0));
endmodule

// File: rtl/tracecap_trig.sv
module tracecap_trig #(
    parameter int W = 64
) (
    input  logic [W-1:0] trace,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] cmp,
    output logic         hit
);
    assign hit = (((trace ^ cmp) & mask) == '0);
endmodule

// File: rtl/tracecap.sv
module tracecap
    import tracecap_pkg::*;
#(
    parameter int W     = TRACE_W,
    parameter int DEPTH = CAP_DEPTH,
    parameter int LW    = LEN_W,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  trace,
    output logic [W-1:0]  q,
    output logic          upd,
    input  logic          ir_we,
    input  logic [2:0]    ir_code,
    input  logic          dr_go,
    input  logic [1:0]    dr_seg,
    input  logic [LW-1:0] dr_len,
    input  logic [W-1:0]  dr_wdata,
    output logic          dr_rvalid,
    output logic [W-1:0]  dr_rdata
);
    op_e           ir;
    cap_e          st, st_nx;
    logic [W-1:0]  mask_r, cmp_r, word, load_val, head, stat;
    logic [CW-1:0] cnt;
    logic          commit, hit, push, pop, full, empty;
    logic          wr_mask, wr_cmp, wr_out;
    seg_e          seg;

    assign seg = seg_e'(dr_seg);

    tracecap_trig #(.W(W)) u_trig (
        .trace(trace), .mask(mask_r), .cmp(cmp_r), .hit(hit)
    );

    tracecap_seg #(.W(W), .LW(LW)) u_seg (
        .clk(clk), .rst_n(rst_n), .go(dr_go), .seg(seg), .len(dr_len),
        .wdata(dr_wdata), .load_val(load_val), .commit(commit), .word(word),
        .rvalid(dr_rvalid), .rdata(dr_rdata)
    );

    tracecap_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clr(wr_mask), .push(push), .din(trace),
        .pop(pop), .head(head), .count(cnt), .full(full), .empty(empty)
    );

    assign wr_mask = commit && (ir == OP_MASK);
    assign wr_cmp  = commit && (ir == OP_CMP);
    assign wr_out  = commit && (ir == OP_OUT);
    assign pop     = dr_go && (ir == OP_READ) && seg_opens(seg);
    assign push    = (st == CAP_ARMED && hit) || (st == CAP_RUN);

    always_comb begin
        stat          = '0;
        stat[0]       = (st == CAP_DONE);
        stat[1]       = (st == CAP_ARMED);
        stat[2]       = (st == CAP_RUN);
        stat[8 +: CW] = cnt;
        case (ir)
            OP_READ: load_val = empty ? '0 : head;
            OP_STAT: load_val = stat;
            default: load_val = '0;
        endcase
    end

    always_comb begin
        st_nx = st;
        if (wr_mask) st_nx = CAP_ARMED;
        else begin
            case (st)
                CAP_ARMED: if (hit) st_nx = CAP_RUN;
                CAP_RUN:   if (full) st_nx = CAP_DONE;
                default:   st_nx = st;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir     <= OP_NONE;
            st     <= CAP_IDLE;
            mask_r <= '0;
            cmp_r  <= '0;
            q      <= '0;
            upd    <= 1'b0;
        end else begin
            if (ir_we) ir <= op_e'(ir_code);
            st  <= st_nx;
            upd <= wr_out;
            if (wr_out)  q      <= word;
            if (wr_mask) mask_r <= word;
            if (wr_cmp)  cmp_r  <= word;
        end
    end

    p_q_only_on_upd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q) |-> upd);

    p_mask_rearm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask |=> (st == CAP_ARMED && cnt == '0));

    p_done_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st == CAP_DONE) |-> full);

    p_idle_no_push_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CAP_IDLE || st == CAP_DONE) && !wr_mask |=> $stable(cnt) || $past(pop));
endmodule

// File: tb/tracecap_test.sv
module tracecap_test;
    localparam int W = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [31:0]   trace_cnt = 32'd0;
    logic [W-1:0]  trace;
    logic [W-1:0]  q;
    logic          upd;
    logic          ir_we = 1'b0;
    logic [2:0]    ir_code = 3'd0;
    logic          dr_go = 1'b0;
    logic [1:0]    dr_seg = 2'd0;
    logic [6:0]    dr_len = 7'd0;
    logic [W-1:0]  dr_wdata = '0;
    logic          dr_rvalid;
    logic [W-1:0]  dr_rdata;

    int errors = 0;
    int checks = 0;
    logic [W-1:0] exp_q [$];
    string        tag_q [$];

    always #10 clk = ~clk;
    always @(posedge clk) trace_cnt <= trace_cnt + 32'd1;
    assign trace = {~trace_cnt, trace_cnt};

    tracecap uut (
        .clk(clk), .rst_n(rst_n), .trace(trace), .q(q), .upd(upd),
        .ir_we(ir_we), .ir_code(ir_code), .dr_go(dr_go), .dr_seg(dr_seg),
        .dr_len(dr_len), .dr_wdata(dr_wdata), .dr_rvalid(dr_rvalid),
        .dr_rdata(dr_rdata)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data as results appear
    always @(negedge clk) begin
        if (rst_n && dr_rvalid) begin
            if (exp_q.size() == 0) chk("R8 unexpected rvalid", 64'd1, 64'd0);
            else chk(tag_q.pop_front(), dr_rdata, exp_q.pop_front());
        end
    end

    task automatic set_ir(input logic [2:0] c);
        @(negedge clk);
        ir_we = 1'b1; ir_code = c;
        @(negedge clk);
        ir_we = 1'b0;
    endtask

    task automatic xfer(input logic [1:0] s, input logic [6:0] n,
                        input logic [W-1:0] d, input logic [W-1:0] e, input string tag);
        @(negedge clk);
        dr_go = 1'b1; dr_seg = s; dr_len = n; dr_wdata = d;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        dr_go = 1'b0;
    endtask

    function automatic logic [W-1:0] smp(input logic [31:0] c);
        return {~c, c};
    endfunction

    initial begin
        logic [W-1:0] v1, v2, s;
        logic [31:0]  c0, tt;
        v1 = 64'h0123_4567_89AB_CDEF;
        v2 = 64'hFEDC_BA98_7654_3210;

        repeat (4) @(negedge clk);
        chk("R1 q in reset", q, '0);
        chk("R1 upd in reset", {63'd0, upd}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 q after reset", q, '0);
        chk("R1 rvalid after reset", {63'd0, dr_rvalid}, '0);
        set_ir(3'd5);
        xfer(2'd0, 7'd64, '0, 64'h0, "R1 R10 status after reset");

        // R3: single-segment write of q
        set_ir(3'd3);
        @(negedge clk);
        dr_go = 1'b1; dr_seg = 2'd0; dr_len = 7'd64; dr_wdata = v1;
        exp_q.push_back('0); tag_q.push_back("R2 write read data");
        @(negedge clk);
        dr_go = 1'b0;
        chk("R3 upd after single write", {63'd0, upd}, 64'd1);
        chk("R3 q after single write", q, v1);
        @(negedge clk);
        chk("R3 upd lasts one cycle", {63'd0, upd}, '0);
        chk("R3 q holds", q, v1);

        // R4: segmented write 16/32/full-width-coded, upper junk ignored
        xfer(2'd1, 7'd16, v2 | 64'hFFFF_0000_0000_0000, '0, "R4 first seg rd");
        chk("R3 R4 no update on first seg", {63'd0, upd}, '0);
        chk("R3 R4 q unchanged on first seg", q, v1);
        xfer(2'd2, 7'd32, (v2 >> 16) | 64'hABCD_0000_0000_0000, '0, "R4 mid seg rd");
        chk("R4 q unchanged on mid seg", q, v1);
        @(negedge clk);
        dr_go = 1'b1; dr_seg = 2'd3; dr_len = 7'd0; dr_wdata = v2 >> 48;
        exp_q.push_back('0); tag_q.push_back("R4 last seg rd");
        @(negedge clk);
        dr_go = 1'b0;
        chk("R4 segmented q assembly", q, v2);
        chk("R3 upd on last seg", {63'd0, upd}, 64'd1);

        // R2: unused code has no effect
        set_ir(3'd6);
        xfer(2'd0, 7'd64, 64'h5555_5555_5555_5555, '0, "R2 unused code read zero");
        chk("R2 unused code leaves q", q, v2);
        chk("R2 unused code no upd", {63'd0, upd}, '0);

        // R5 zero mask fires at once; R6 fill
        set_ir(3'd1);
        @(negedge clk);
        c0 = trace_cnt;
        dr_go = 1'b1; dr_seg = 2'd0; dr_len = 7'd64; dr_wdata = '0;
        exp_q.push_back('0); tag_q.push_back("R2 mask write rd");
        @(negedge clk);
        dr_go = 1'b0;
        repeat (25) @(negedge clk);
        set_ir(3'd5);
        xfer(2'd0, 7'd64, '0, 64'h1001, "R6 R10 done with full count");
        set_ir(3'd4);
        s = smp(c0 + 32'd1);
        xfer(2'd1, 7'd16, '0, {48'd0, s[15:0]}, "R5 R8 first seg of first sample");
        xfer(2'd2, 7'd32, '0, {32'd0, s[47:16]}, "R8 mid seg");
        xfer(2'd3, 7'd16, '0, {48'd0, s[63:48]}, "R8 last seg");
        for (int i = 1; i < 16; i++)
            xfer(2'd0, 7'd64, '0, smp(c0 + 32'd1 + 32'(i)), "R6 R8 sample order");
        xfer(2'd0, 7'd64, '0, '0, "R9 empty read zero");
        set_ir(3'd5);
        xfer(2'd0, 7'd64, '0, 64'h0001, "R9 count stays zero");

        // R5 masked trigger, R7 rearm, R11 push and pop together
        @(negedge clk);
        tt = trace_cnt + 32'd80;
        set_ir(3'd2);
        xfer(2'd0, 7'd64, {32'hDEAD_BEEF, tt}, '0, "R2 cmp write rd");
        set_ir(3'd1);
        xfer(2'd0, 7'd64, 64'h0000_0000_0000_FFFF, '0, "R2 mask write rd");
        set_ir(3'd5);
        xfer(2'd0, 7'd64, '0, 64'h0002, "R7 armed and cleared");
        set_ir(3'd4);
        while (trace_cnt != tt) @(negedge clk);
        xfer(2'd0, 7'd64, '0, smp(tt), "R5 R11 trigger sample popped");
        repeat (25) @(negedge clk);
        set_ir(3'd5);
        xfer(2'd0, 7'd64, '0, 64'h1001, "R11 full after concurrent pop");
        set_ir(3'd4);
        for (int i = 1; i <= 16; i++)
            xfer(2'd0, 7'd64, '0, smp(tt + 32'(i)), "R11 samples after trigger");

        repeat (3) @(negedge clk);
        chk("R8 all reads answered", 64'(exp_q.size()), '0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule